// File: doc/BRIEF.md
# Double-Buffered PWM Down-Counter Timer

This block is one timer channel with a 16-bit down-counter. The counter steps once for each clock cycle in which the tick input is high. Software never writes the running counter. It writes a count buffer and a compare buffer through a small register port. Those values reach the active count and compare registers only in two ways: while a manual-update control bit is held, or at expiry when auto-reload is on.

The channel drives a PWM level. The level becomes active when the count reaches the compare value, and it falls back to idle at expiry. An inverter bit can flip the polarity at the pin.

Each expiry raises a one-cycle interrupt pulse. In one-shot mode the channel then halts by clearing its own run bit. The live count can be read back through a dedicated read-only address.

A typical sequence has four steps:
- load both buffers;
- pulse manual update for one write;
- write the control word with run set and update clear;
- service the interrupt on each expiry.

Top module: `pwm_timer`

## Requirements
- R1: When run is set and update is clear, each cycle with tick_i high decrements a nonzero active count by one. Without a tick the count holds.
- R2: Register addresses:
  - address 0 is control, with bit 0 run, bit 1 manual update, bit 2 invert and bit 3 auto-reload;
  - address 1 is the count buffer;
  - address 2 is the compare buffer;
  - address 3 returns the live count and ignores writes.

  rd_data_o follows rd_addr_i combinationally, and control reads are zero-extended. A write takes effect at the clock edge.
- R3: While the update bit is set, every clock edge copies both buffers into the active count and compare registers, forces the PWM level idle and performs no counting.
- R4: Writing a buffer does not change the active count or compare value until the next update or auto-reload.
- R5: With auto-reload set, the tick that would bring the count to zero instead loads both buffers into the active registers, so the period is the count-buffer value in ticks.
- R6: Without auto-reload, the expiring tick leaves the count at 0 and clears the run bit, which reads back as 0. A control write in the same cycle takes precedence over the clear.
- R7: irq_o is high for exactly the one cycle after each expiring clock edge. It stays low at all other times.
- R8: The PWM level becomes active (1 before inversion) on the tick that makes the count equal a nonzero compare value. It returns to idle (0) at expiry.
- R9: pwm_o equals the PWM level XOR the invert bit. A change of the invert bit shows up without waiting for a tick.
- R10: After reset, all registers read 0, and pwm_o and irq_o are 0.
- R11: A running channel whose count is already 0 neither decrements nor raises irq_o on a tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Count enable, one step per high cycle |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Write address |
| wr_data_i | input | 16 | Write data |
| rd_addr_i | input | 2 | Read address |
| rd_data_o | output | 16 | Read data, combinational from rd_addr_i |
| pwm_o | output | 1 | PWM output after polarity control |
| irq_o | output | 1 | One-cycle expiry pulse |

## Verification
The assertions are checked on every cycle. They cover the following rules:
- the count holds without a tick, and also across a count-buffer write;
- the update bit copies the count buffer into the active count;
- a one-shot expiry clears run and leaves zero;
- an interrupt is only raised by a tick on a running channel, and a zero count never raises one;
- the pin sits at its idle polarity whenever the interrupt is high.

Some behaviour shows only in the bench's scenarios. This includes the exact tick on which the PWM level rises, the reload period under auto-reload, and the precedence of a control write over the self-clear. It also includes the immediate effect of inversion, and the long random mix of buffer writes, update pulses and irregular ticks that is compared against a cycle model.

// File: rtl/pwm_timer_pkg.sv
`timescale 1ns/1ps
package pwm_timer_pkg;
  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_CBUF = 2'd1,
    REG_PBUF = 2'd2,
    REG_LIVE = 2'd3
  } reg_addr_e;

  // bit 0 run, bit 1 update, bit 2 invert, bit 3 auto-reload
  typedef struct packed {
    logic reload;
    logic invert;
    logic update;
    logic run;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/pwm_timer_regs.sv
`timescale 1ns/1ps
module pwm_timer_regs
  import pwm_timer_pkg::*;
#(
  parameter int W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_addr_i,
  input  logic [W-1:0]     wr_data_i,
  input  logic [1:0]       rd_addr_i,
  input  logic             stop_i,
  input  logic [W-1:0]     live_i,
  output ctrl_t            ctrl_o,
  output logic [W-1:0]     cbuf_o,
  output logic [W-1:0]     pbuf_o,
  output logic [W-1:0]     rd_data_o
);
  localparam int PAD_W = W - CTRL_W;

  ctrl_t  ctrl_q;
  logic   wr_ctrl, wr_cbuf, wr_pbuf;
  logic   unused_hi;

  assign wr_ctrl   = wr_en_i && (reg_addr_e'(wr_addr_i) == REG_CTRL);
  assign wr_cbuf   = wr_en_i && (reg_addr_e'(wr_addr_i) == REG_CBUF);
  assign wr_pbuf   = wr_en_i && (reg_addr_e'(wr_addr_i) == REG_PBUF);
  assign unused_hi = ^wr_data_i[W-1:CTRL_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      cbuf_o <= '0;
      pbuf_o <= '0;
    end else begin
      // software write wins over the one-shot self-clear
      if (wr_ctrl)      ctrl_q     <= ctrl_t'(wr_data_i[CTRL_W-1:0]);
      else if (stop_i)  ctrl_q.run <= 1'b0;
      if (wr_cbuf) cbuf_o <= wr_data_i;
      if (wr_pbuf) pbuf_o <= wr_data_i;
    end
  end

  assign ctrl_o = ctrl_q;

  always_comb begin
    unique case (reg_addr_e'(rd_addr_i))
      REG_CTRL: rd_data_o = {{PAD_W{1'b0}}, ctrl_q};
      REG_CBUF: rd_data_o = cbuf_o;
      REG_PBUF: rd_data_o = pbuf_o;
      default:  rd_data_o = live_i;
    endcase
  end
endmodule

// File: rtl/pwm_timer_core.sv
`timescale 1ns/1ps
module pwm_timer_core
  import pwm_timer_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  ctrl_t        ctrl_i,
  input  logic [W-1:0] cbuf_i,
  input  logic [W-1:0] pbuf_i,
  output logic [W-1:0] cnt_o,
  output logic         lvl_o,
  output logic         irq_o,
  output logic         stop_o
);
  logic [W-1:0] cnt_q, cmp_q, dec;
  logic         step, expire;

  assign dec    = cnt_q - W'(1);
  assign step   = ctrl_i.run && !ctrl_i.update && tick_i && (cnt_q != '0);
  assign expire = step && (dec == '0);
  assign stop_o = expire && !ctrl_i.reload;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      cmp_q <= '0;
      lvl_o <= 1'b0;
      irq_o <= 1'b0;
    end else begin
      irq_o <= expire;
      if (ctrl_i.update) begin
        cnt_q <= cbuf_i;
        cmp_q <= pbuf_i;
        lvl_o <= 1'b0;
      end else if (expire) begin
        lvl_o <= 1'b0;
        if (ctrl_i.reload) begin
          cnt_q <= cbuf_i;
          cmp_q <= pbuf_i;
        end else begin
          cnt_q <= '0;
        end
      end else if (step) begin
        cnt_q <= dec;
        if (dec == cmp_q) lvl_o <= 1'b1;
      end
    end
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/pwm_timer_out.sv
`timescale 1ns/1ps
module pwm_timer_out (
  input  logic lvl_i,
  input  logic invert_i,
  output logic pwm_o
);
  assign pwm_o = lvl_i ^ invert_i;
endmodule

// File: rtl/pwm_timer.sv
`timescale 1ns/1ps
module pwm_timer
  import pwm_timer_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         wr_en_i,
  input  logic [1:0]   wr_addr_i,
  input  logic [W-1:0] wr_data_i,
  input  logic [1:0]   rd_addr_i,
  output logic [W-1:0] rd_data_o,
  output logic         pwm_o,
  output logic         irq_o
);
  ctrl_t        ctrl_q;
  logic [W-1:0] cbuf_q, pbuf_q, cnt_q;
  logic         lvl, stop;

  pwm_timer_regs #(.W(W)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i, .rd_addr_i,
    .stop_i(stop), .live_i(cnt_q), .ctrl_o(ctrl_q),
    .cbuf_o(cbuf_q), .pbuf_o(pbuf_q), .rd_data_o
  );

  pwm_timer_core #(.W(W)) u_core (
    .clk_i, .rst_ni, .tick_i, .ctrl_i(ctrl_q), .cbuf_i(cbuf_q),
    .pbuf_i(pbuf_q), .cnt_o(cnt_q), .lvl_o(lvl), .irq_o, .stop_o(stop)
  );

  pwm_timer_out u_out (.lvl_i(lvl), .invert_i(ctrl_q.invert), .pwm_o);
endmodule

// File: rtl/pwm_timer_chk.sv
`timescale 1ns/1ps
module pwm_timer_chk #(
  parameter int W = 16
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         tick_i,
  input logic         wr_en_i,
  input logic [1:0]   wr_addr_i,
  input logic         pwm_o,
  input logic         irq_o,
  input logic         c_run,
  input logic         c_upd,
  input logic         c_inv,
  input logic         c_rld,
  input logic [W-1:0] cnt,
  input logic [W-1:0] cbuf
);
  // R1
  hold_without_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !c_upd) |=> $stable(cnt));

  // R3
  update_copies_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    c_upd |=> (cnt == $past(cbuf)));

  // R4
  buffer_write_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == 2'd1 && !c_upd && !tick_i) |=> $stable(cnt));

  // R6
  oneshot_halts_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && c_run && !c_upd && !c_rld && cnt == W'(1) && !(wr_en_i && wr_addr_i == 2'd0))
    |=> (!c_run && cnt == '0));

  // R7
  irq_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ($past(tick_i) && $past(c_run) && !$past(c_upd)));

  // R8
  idle_at_expiry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (pwm_o == c_inv));

  // R11
  zero_silent_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt == '0 && !c_upd) |=> !irq_o);
endmodule

bind pwm_timer pwm_timer_chk #(.W(W)) u_chk (
  .clk_i, .rst_ni, .tick_i, .wr_en_i, .wr_addr_i, .pwm_o, .irq_o,
  .c_run(ctrl_q.run), .c_upd(ctrl_q.update), .c_inv(ctrl_q.invert),
  .c_rld(ctrl_q.reload), .cnt(cnt_q), .cbuf(cbuf_q)
);

// File: tb/tb_pwm_timer.sv
`timescale 1ns/1ps
module tb_pwm_timer;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         tick_i = 1'b0;
  logic         wr_en_i = 1'b0;
  logic [1:0]   wr_addr_i = '0;
  logic [W-1:0] wr_data_i = '0;
  logic [1:0]   rd_addr_i = '0;
  logic [W-1:0] rd_data_o;
  logic         pwm_o, irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pwm_timer #(.W(W)) dut (
    .clk_i(clk), .rst_ni, .tick_i, .wr_en_i, .wr_addr_i, .wr_data_i,
    .rd_addr_i, .rd_data_o, .pwm_o, .irq_o
  );

  // cycle model built from the requirements
  logic         m_run = 0, m_upd = 0, m_inv = 0, m_rld = 0;
  logic [W-1:0] m_cbuf = 0, m_pbuf = 0, m_cnt = 0, m_cmp = 0;
  logic         m_lvl = 0, m_irq = 0;
  logic [W-1:0] s_rd;
  logic         s_pwm, s_irq;

  function automatic logic [W-1:0] exp_rd(input logic [1:0] a);
    case (a)
      2'd0:    return W'({m_rld, m_inv, m_upd, m_run});
      2'd1:    return m_cbuf;
      2'd2:    return m_pbuf;
      default: return m_cnt;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model_edge(input logic t, input logic we, input logic [1:0] wa,
                            input logic [W-1:0] wd);
    logic clr = 0;
    logic [W-1:0] ocb = m_cbuf, opb = m_pbuf;
    m_irq = 0;
    if (m_upd) begin
      m_cnt = ocb; m_cmp = opb; m_lvl = 0;
    end else if (m_run && t && m_cnt != 0) begin
      if (m_cnt == 1) begin
        m_irq = 1; m_lvl = 0;
        if (m_rld) begin m_cnt = ocb; m_cmp = opb; end
        else begin m_cnt = 0; clr = 1; end
      end else begin
        m_cnt = m_cnt - 1;
        if (m_cnt == m_cmp) m_lvl = 1;
      end
    end
    if (we && wa == 2'd0) {m_rld, m_inv, m_upd, m_run} = wd[3:0];
    else if (clr) m_run = 0;
    if (we && wa == 2'd1) m_cbuf = wd;
    if (we && wa == 2'd2) m_pbuf = wd;
  endtask

  // drive at negedge, sample 1 ns later, then advance the model past the edge
  task automatic step(input logic t, input logic we, input logic [1:0] wa,
                      input logic [W-1:0] wd, input logic [1:0] ra);
    @(negedge clk);
    tick_i = t; wr_en_i = we; wr_addr_i = wa; wr_data_i = wd; rd_addr_i = ra;
    #1;
    s_rd = rd_data_o; s_pwm = pwm_o; s_irq = irq_o;
    chk(ra == 2'd3 ? "R1 live count" : "R2 register read", 32'(s_rd), 32'(exp_rd(ra)));
    chk("R8/R9 pwm", 32'(s_pwm), 32'(m_lvl ^ m_inv));
    chk("R7 irq", 32'(s_irq), 32'(m_irq));
    model_edge(t, we, wa, wd);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    // R10 reset state
    step(0, 0, 0, 0, 3); chk("R10 live", 32'(s_rd), 0);
    chk("R10 pwm", 32'(s_pwm), 0); chk("R10 irq", 32'(s_irq), 0);
    step(0, 0, 0, 0, 0); chk("R10 ctrl", 32'(s_rd), 0);

    // one-shot: count 5, compare 2
    step(0, 1, 1, 5, 0);
    step(0, 1, 2, 2, 0);
    step(0, 1, 0, 16'h2, 0);
    step(1, 1, 0, 16'h1, 3);           // edge: update copies, tick ignored
    step(1, 0, 0, 0, 3); chk("R3 update load", 32'(s_rd), 5);
    step(1, 0, 0, 0, 3); chk("R1 decrement", 32'(s_rd), 4);
    step(1, 0, 0, 0, 3); chk("R8 level before compare", 32'(s_pwm), 0);
    step(1, 0, 0, 0, 3); chk("R8 level at compare", 32'(s_pwm), 1);
    step(1, 0, 0, 0, 3); chk("R1 count one", 32'(s_rd), 1);   // expiring tick
    step(1, 0, 0, 0, 3); chk("R7 irq pulse", 32'(s_irq), 1);
    chk("R6 count stays zero", 32'(s_rd), 0); chk("R8 idle at expiry", 32'(s_pwm), 0);
    step(0, 0, 0, 0, 0); chk("R7 irq single", 32'(s_irq), 0);
    chk("R6 run cleared", 32'(s_rd), 0);

    // R11 running with zero count
    step(0, 1, 0, 16'h1, 0);
    step(1, 0, 0, 0, 3);
    step(1, 0, 0, 0, 3);
    step(0, 0, 0, 0, 3); chk("R11 no irq", 32'(s_irq), 0); chk("R11 stays zero", 32'(s_rd), 0);

    // R9 invert while idle
    step(0, 1, 0, 16'h4, 0);
    step(0, 0, 0, 0, 0); chk("R9 inverted idle", 32'(s_pwm), 1);

    // R4, R5: auto-reload, count 6, buffer rewritten mid-period
    step(0, 1, 1, 6, 0);
    step(0, 1, 2, 0, 0);
    step(0, 1, 0, 16'ha, 0);
    step(0, 1, 0, 16'h9, 3);
    step(1, 0, 0, 0, 3); chk("R3 reload value", 32'(s_rd), 6);
    step(1, 0, 0, 0, 3);
    step(1, 1, 1, 9, 3); chk("R4 before write", 32'(s_rd), 4);
    step(1, 0, 0, 0, 3); chk("R4 count kept", 32'(s_rd), 3);
    step(1, 0, 0, 0, 3);
    step(1, 0, 0, 0, 3);               // expiring tick reloads
    step(0, 0, 0, 0, 3); chk("R5 reloaded", 32'(s_rd), 9); chk("R5 irq", 32'(s_irq), 1);
    step(0, 0, 0, 0, 0); chk("R5 still running", 32'(s_rd), 32'h9);
    step(0, 1, 3, 16'h1234, 3);
    step(0, 0, 0, 0, 3); chk("R2 live write ignored", 32'(s_rd), 9);

    // R6 precedence: control write on the expiring edge
    step(0, 1, 1, 2, 0);
    step(0, 1, 0, 16'h2, 0);
    step(0, 1, 0, 16'h1, 0);
    step(1, 0, 0, 0, 3);
    step(1, 1, 0, 16'h1, 3);           // expiry + rewrite run
    step(0, 0, 0, 0, 0); chk("R6 write wins", 32'(s_rd), 1);

    // random mix
    for (int i = 0; i < 4000; i++) begin
      int r = $urandom % 16;
      logic t = 1'($urandom % 2);
      logic [1:0] ra = 2'($urandom % 4);
      if (r < 2)       step(t, 1, 1, W'(1 + $urandom % 12), ra);
      else if (r == 2) step(t, 1, 2, W'($urandom % 10), ra);
      else if (r == 3) step(t, 1, 0, W'({1'($urandom % 2), 1'($urandom % 2),
                                          1'($urandom % 4 == 0), 1'($urandom % 4 != 0)}), ra);
      else if (r == 4) step(t, 1, 3, W'($urandom), ra);
      else             step(t, 0, 0, 0, ra);
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule